// File: doc/BRIEF.md
# Instruction-Driven Memory Copy Engine

This block is a coprocessor-side copy engine. A host core hands it custom instructions over a valid/ready command channel. One instruction stores a source base and a destination base address. The other instruction carries an element count and starts a copy of that many 64-bit words from the source region to the destination region.

The engine reaches memory through a simple request/response port that carries 64-bit loads and stores. It keeps exactly one request in flight at a time. Every command gets one answer on a response channel. The answer for a copy command is held back until the last store of the copy has been acknowledged.

The stored base addresses remain in place after a copy finishes. A single address-setup command can therefore be followed by any number of copy commands.

Top module: `mcpy_engine`

## Requirements
- R1: After reset, `cmd_ready_o` is 1, `rsp_valid_o` is 0 and `mem_req_valid_o` is 0.
- R2: A command with opcode 7'b0101011 and function 0 stores `cmd_rs1_i` as the source base and `cmd_rs2_i` as the destination base. It raises `rsp_valid_o` with data 1 in the cycle after it is accepted.
- R3: A command with opcode 7'b0101011 and function 1 copies N elements, where N is `cmd_rs1_i`. Element k is loaded from source base + 8k and stored to destination base + 8k, in ascending k, with the load and store strictly alternating.
- R4: No memory request is issued while a response from an earlier request is still outstanding. A store carries the data returned by the matching load.
- R5: The completion response of a copy (data 1) appears only after the memory response of the final store.
- R6: A copy with N = 0 responds with data 1 in the cycle after acceptance and issues no memory request.
- R7: Every response carries the `cmd_rd_i` of its command. It stays valid with stable data and index until `rsp_ready_i` is 1, and `cmd_ready_o` is 0 while it waits.
- R8: `cmd_ready_o` is 0 while a copy is in progress.
- R9: An opcode 7'b0101011 command whose function is neither 0 nor 1 responds with data 0 in the cycle after acceptance. It performs no memory access and leaves the stored bases unchanged.
- R10: A command with any other opcode responds with data 0 and has no other effect.
- R11: Stored bases are kept across copies; a second copy without a new setup uses the same bases.
- R12: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request address, write flag and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Engine can take a command |
| cmd_opcode_i | input | 7 | Major opcode of the instruction |
| cmd_funct_i | input | 7 | Function field selecting the operation |
| cmd_rd_i | input | 5 | Destination register index |
| cmd_rs1_i | input | 64 | First source operand |
| cmd_rs2_i | input | 64 | Second source operand |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Host accepts the response |
| rsp_rd_o | output | 5 | Register index for the response |
| rsp_data_o | output | 64 | Response value |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_we_o | output | 1 | 1 for store, 0 for load |
| mem_req_addr_o | output | 64 | Byte address |
| mem_req_wdata_o | output | 64 | Store data |
| mem_rsp_valid_i | input | 1 | Memory response (load data or store acknowledge) |
| mem_rsp_rdata_i | input | 64 | Load data |

## Verification
The bench targets the places where an address/count engine slips. One is an off-by-one in the element counter, which would copy one word too many or too few. Another is an early completion that answers before the final store is acknowledged. A third is a zero-length copy that still touches memory or never answers.

A back-pressured memory, with stalled requests and slow responses, exposes a request that changes while stalled or a second request launched before the previous response arrives. A stalled response channel shows whether the engine drops or alters its answer, or accepts a new command while one is pending.

Unknown function codes and foreign opcodes are followed by a real copy. This reveals whether they corrupted the stored bases or started a transfer.

// File: rtl/mcpy_pkg.sv
package mcpy_pkg;
  localparam int unsigned XLEN       = 64;
  localparam int unsigned RD_W       = 5;
  localparam int unsigned OPC_W      = 7;
  localparam int unsigned FUNCT_W    = 7;
  localparam int unsigned ELEM_SHIFT = 3;  // 8 bytes per element
  localparam logic [OPC_W-1:0]   OPC_CUSTOM1 = 7'b0101011;
  localparam logic [FUNCT_W-1:0] FN_SETUP    = 7'd0;
  localparam logic [FUNCT_W-1:0] FN_COPY     = 7'd1;

  typedef enum logic [1:0] {
    KIND_SETUP,
    KIND_COPY,
    KIND_BAD
  } cmd_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LD_REQ,
    SQ_LD_WAIT,
    SQ_ST_REQ,
    SQ_ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/mcpy_decode.sv
module mcpy_decode
  import mcpy_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output cmd_kind_e          kind_o
);
  always_comb begin
    kind_o = KIND_BAD;
    if (opcode_i == OPC_CUSTOM1) begin
      if (funct_i == FN_SETUP)     kind_o = KIND_SETUP;
      else if (funct_i == FN_COPY) kind_o = KIND_COPY;
    end
  end
endmodule

// File: rtl/mcpy_base_regs.sv
module mcpy_base_regs #(
  parameter int unsigned AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
    end else if (load_i) begin
      src_o <= src_i;
      dst_o <= dst_i;
    end
  end
endmodule

// File: rtl/mcpy_seq.sv
module mcpy_seq
  import mcpy_pkg::*;
#(
  parameter int unsigned AW = 64,
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] count_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_we_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_rdata_i
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] idx_q, count_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] offset;
  logic          last_elem;

  assign offset    = idx_q << ELEM_SHIFT;
  assign last_elem = (idx_q == count_q - 1'b1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:    if (start_i)     state_d = SQ_LD_REQ;
      SQ_LD_REQ:  if (req_ready_i) state_d = SQ_LD_WAIT;
      SQ_LD_WAIT: if (rsp_valid_i) state_d = SQ_ST_REQ;
      SQ_ST_REQ:  if (req_ready_i) state_d = SQ_ST_WAIT;
      SQ_ST_WAIT: if (rsp_valid_i) state_d = last_elem ? SQ_IDLE : SQ_LD_REQ;
      default:                     state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      count_q <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SQ_IDLE && start_i) begin
        idx_q   <= '0;
        count_q <= count_i;
      end
      if (state_q == SQ_LD_WAIT && rsp_valid_i) data_q <= rsp_rdata_i;
      if (state_q == SQ_ST_WAIT && rsp_valid_i && !last_elem) idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o      = (state_q != SQ_IDLE);
  assign done_o      = (state_q == SQ_ST_WAIT) && rsp_valid_i && last_elem;
  assign req_valid_o = (state_q == SQ_LD_REQ) || (state_q == SQ_ST_REQ);
  assign req_we_o    = (state_q == SQ_ST_REQ);
  assign req_addr_o  = (state_q == SQ_ST_REQ) ? dst_base_i + offset : src_base_i + offset;
  assign req_wdata_o = data_q;

  assert_req_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
                                    && $stable(req_we_o) && $stable(req_wdata_o));

  // R4: a new request never follows an accepted one directly; a response must come in between
  assert_one_outstanding_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> !req_valid_o);
endmodule

// File: rtl/mcpy_rsp_reg.sv
module mcpy_rsp_reg
  import mcpy_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic [RD_W-1:0] arm_rd_i,
  input  logic            set_i,
  input  logic [DW-1:0]   set_data_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [RD_W-1:0] rd_o,
  output logic [DW-1:0]   data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rd_o    <= '0;
      data_o  <= '0;
    end else begin
      if (arm_i) rd_o <= arm_rd_i;
      if (set_i) begin
        valid_o <= 1'b1;
        data_o  <= set_data_i;
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  assert_rsp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(rd_o));
endmodule

// File: rtl/mcpy_engine.sv
module mcpy_engine
  import mcpy_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [OPC_W-1:0]   cmd_opcode_i,
  input  logic [FUNCT_W-1:0] cmd_funct_i,
  input  logic [RD_W-1:0]    cmd_rd_i,
  input  logic [XLEN-1:0]    cmd_rs1_i,
  input  logic [XLEN-1:0]    cmd_rs2_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [RD_W-1:0]    rsp_rd_o,
  output logic [XLEN-1:0]    rsp_data_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic               mem_req_we_o,
  output logic [XLEN-1:0]    mem_req_addr_o,
  output logic [XLEN-1:0]    mem_req_wdata_o,
  input  logic               mem_rsp_valid_i,
  input  logic [XLEN-1:0]    mem_rsp_rdata_i
);
  cmd_kind_e     kind;
  logic          cmd_fire, setup_fire, copy_fire, bad_fire, zero_copy;
  logic          seq_busy, seq_done, rsp_set;
  logic [XLEN-1:0] src_base, dst_base;

  mcpy_decode i_decode (
    .opcode_i (cmd_opcode_i),
    .funct_i  (cmd_funct_i),
    .kind_o   (kind)
  );

  assign cmd_ready_o = !seq_busy && !rsp_valid_o;
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign setup_fire  = cmd_fire && (kind == KIND_SETUP);
  assign copy_fire   = cmd_fire && (kind == KIND_COPY);
  assign bad_fire    = cmd_fire && (kind == KIND_BAD);
  assign zero_copy   = copy_fire && (cmd_rs1_i == '0);

  mcpy_base_regs #(.AW(XLEN)) i_base_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (setup_fire),
    .src_i  (cmd_rs1_i),
    .dst_i  (cmd_rs2_i),
    .src_o  (src_base),
    .dst_o  (dst_base)
  );

  mcpy_seq #(.AW(XLEN), .DW(XLEN)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (copy_fire && !zero_copy),
    .count_i     (cmd_rs1_i),
    .src_base_i  (src_base),
    .dst_base_i  (dst_base),
    .busy_o      (seq_busy),
    .done_o      (seq_done),
    .req_valid_o (mem_req_valid_o),
    .req_ready_i (mem_req_ready_i),
    .req_we_o    (mem_req_we_o),
    .req_addr_o  (mem_req_addr_o),
    .req_wdata_o (mem_req_wdata_o),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_rdata_i (mem_rsp_rdata_i)
  );

  assign rsp_set = setup_fire || bad_fire || zero_copy || seq_done;

  mcpy_rsp_reg #(.DW(XLEN)) i_rsp_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (cmd_fire),
    .arm_rd_i   (cmd_rd_i),
    .set_i      (rsp_set),
    .set_data_i (bad_fire ? '0 : XLEN'(1)),
    .ready_i    (rsp_ready_i),
    .valid_o    (rsp_valid_o),
    .rd_o       (rsp_rd_o),
    .data_o     (rsp_data_o)
  );

  assert_setup_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_fire |=> src_base == $past(cmd_rs1_i) && dst_base == $past(cmd_rs2_i)
                   && rsp_valid_o && rsp_data_o == XLEN'(1));

  assert_zero_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_copy |=> rsp_valid_o && !mem_req_valid_o);

  assert_bad_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_fire |=> rsp_valid_o && rsp_data_o == '0 && !mem_req_valid_o);

  assert_busy_blocks_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !cmd_ready_o);
endmodule

// File: tb/test_mcpy_engine.sv
module test_mcpy_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [6:0]  cmd_opcode = '0;
  logic [6:0]  cmd_funct = '0;
  logic [4:0]  cmd_rd = '0;
  logic [63:0] cmd_rs1 = '0;
  logic [63:0] cmd_rs2 = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [4:0]  rsp_rd;
  logic [63:0] rsp_data;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_we;
  logic [63:0] req_addr;
  logic [63:0] req_wdata;
  logic        mrsp_valid = 1'b0;
  logic [63:0] mrsp_rdata = '0;

  localparam logic [6:0] OPC = 7'b0101011;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mcpy_engine i_mcpy_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_opcode_i(cmd_opcode), .cmd_funct_i(cmd_funct), .cmd_rd_i(cmd_rd),
    .cmd_rs1_i(cmd_rs1), .cmd_rs2_i(cmd_rs2),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_rd_o(rsp_rd), .rsp_data_o(rsp_data),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
    .mem_req_we_o(req_we), .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wdata),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_rdata_i(mrsp_rdata)
  );

  // memory model
  logic [63:0] mem [128];
  int          lat = 1;
  int          stall_mod = 0;
  int          tick = 0;
  bit          pend = 0;
  bit          pend_we = 0;
  int          wait_cnt = 0;
  logic [63:0] pend_data = '0;
  int          n_access = 0;
  int          stores_acked = 0;
  int          outst_viol = 0;
  int          stable_viol = 0;
  bit          prev_stall = 0;
  logic [63:0] prev_addr = '0;
  logic [63:0] prev_wdata = '0;
  bit          prev_we = 0;
  logic [63:0] log_addr [64];
  bit          log_we [64];

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 64'hC0DE_0000_0000_0000 | 64'(i * 32'h0101_0101);
    forever begin
      @(negedge clk);
      mrsp_valid = 1'b0;
      req_ready  = 1'b0;
      if (pend) begin
        if (req_valid) outst_viol++;
        wait_cnt--;
        if (wait_cnt <= 0) begin
          mrsp_valid = 1'b1;
          mrsp_rdata = pend_data;
          if (pend_we) stores_acked++;
          pend = 0;
        end
        prev_stall = 0;
      end else if (req_valid) begin
        if (prev_stall && (req_addr != prev_addr || req_we != prev_we ||
                           req_wdata != prev_wdata)) stable_viol++;
        req_ready = (stall_mod == 0) || (tick % stall_mod != 0);
        tick++;
        if (req_ready) begin
          if (n_access < 64) begin
            log_addr[n_access] = req_addr;
            log_we[n_access]   = req_we;
          end
          n_access++;
          if (req_we) mem[req_addr[9:3]] = req_wdata;
          else pend_data = mem[req_addr[9:3]];
          pend_we = req_we;
          pend = 1;
          wait_cnt = lat;
          prev_stall = 0;
        end else begin
          prev_stall = 1;
          prev_addr  = req_addr;
          prev_we    = req_we;
          prev_wdata = req_wdata;
        end
      end else begin
        prev_stall = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [6:0] opc, input logic [6:0] fn, input logic [4:0] rd,
                      input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    cmd_opcode = opc; cmd_funct = fn; cmd_rd = rd; cmd_rs1 = a; cmd_rs2 = b;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp(input logic [4:0] rd, input logic [63:0] data, input string tag);
    int n = 0;
    while (!rsp_valid && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(rsp_valid, {tag, " response arrives"}, 64'(rsp_valid), 64'd1);
    check(rsp_data == data, {tag, " response data"}, rsp_data, data);
    check(rsp_rd == rd, "R7 response rd", 64'(rsp_rd), 64'(rd));
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R1 cmd_ready after reset", 64'(cmd_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(req_valid == 1'b0, "R1 mem_req_valid after reset", 64'(req_valid), 64'd0);
  endtask

  task automatic t_setup(input logic [63:0] s, input logic [63:0] d, input logic [4:0] rd);
    send(OPC, 7'd0, rd, s, d);
    check(rsp_valid == 1'b1, "R2 setup answers next cycle", 64'(rsp_valid), 64'd1);
    wait_rsp(rd, 64'd1, "R2");
  endtask

  task automatic t_copy(input int n, input logic [63:0] s, input logic [63:0] d,
                        input logic [4:0] rd, input string tag);
    logic [63:0] exp [64];
    for (int k = 0; k < n; k++) exp[k] = mem[s[9:3] + k];
    n_access = 0; stores_acked = 0; outst_viol = 0; stable_viol = 0;
    send(OPC, 7'd1, rd, 64'(n), 64'hDEAD);
    check(cmd_ready == 1'b0, {"R8 busy during copy ", tag}, 64'(cmd_ready), 64'd0);
    begin
      int t = 0;
      while (!rsp_valid && t < 5000) begin
        @(negedge clk);
        t++;
      end
    end
    check(stores_acked == n, {"R5 all stores acked before response ", tag},
          64'(stores_acked), 64'(n));
    wait_rsp(rd, 64'd1, {"R5 ", tag});
    check(n_access == 2 * n, {"R3 access count ", tag}, 64'(n_access), 64'(2 * n));
    begin
      int bad = 0;
      for (int k = 0; k < n && 2 * k + 1 < 64; k++) begin
        if (log_we[2*k] != 1'b0 || log_addr[2*k] != s + 64'(8 * k)) bad++;
        if (log_we[2*k+1] != 1'b1 || log_addr[2*k+1] != d + 64'(8 * k)) bad++;
      end
      check(bad == 0, {"R3 load/store order and addresses ", tag}, 64'(bad), 64'd0);
      bad = 0;
      for (int k = 0; k < n; k++) if (mem[d[9:3] + k] != exp[k]) bad++;
      check(bad == 0, {"R4 destination data ", tag}, 64'(bad), 64'd0);
    end
    check(outst_viol == 0, {"R4 single outstanding ", tag}, 64'(outst_viol), 64'd0);
    check(stable_viol == 0, {"R12 stalled request stable ", tag}, 64'(stable_viol), 64'd0);
  endtask

  task automatic t_zero();
    n_access = 0;
    send(OPC, 7'd1, 5'd9, 64'd0, 64'd0);
    check(rsp_valid == 1'b1, "R6 zero count answers next cycle", 64'(rsp_valid), 64'd1);
    wait_rsp(5'd9, 64'd1, "R6");
    repeat (3) @(negedge clk);
    check(n_access == 0, "R6 zero count no access", 64'(n_access), 64'd0);
  endtask

  task automatic t_hold();
    logic [63:0] d0;
    rsp_ready = 1'b0;
    send(OPC, 7'd0, 5'd17, 64'h100, 64'h200);
    d0 = rsp_data;
    repeat (5) @(negedge clk);
    check(rsp_valid == 1'b1, "R7 response held", 64'(rsp_valid), 64'd1);
    check(rsp_data == d0 && rsp_rd == 5'd17, "R7 response stable", rsp_data, d0);
    check(cmd_ready == 1'b0, "R7 cmd_ready low while pending", 64'(cmd_ready), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 response consumed", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_bad_funct();
    n_access = 0;
    send(OPC, 7'd5, 5'd3, 64'h3C0, 64'h3E0);
    check(rsp_valid == 1'b1, "R9 unknown funct answers", 64'(rsp_valid), 64'd1);
    wait_rsp(5'd3, 64'd0, "R9");
    check(n_access == 0, "R9 unknown funct no access", 64'(n_access), 64'd0);
  endtask

  task automatic t_bad_opc();
    n_access = 0;
    send(7'b0001011, 7'd1, 5'd4, 64'd3, 64'h3E0);
    wait_rsp(5'd4, 64'd0, "R10");
    repeat (3) @(negedge clk);
    check(n_access == 0, "R10 foreign opcode no access", 64'(n_access), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_setup(64'h100, 64'h200, 5'd5);
    lat = 1; stall_mod = 0;
    t_copy(5, 64'h100, 64'h200, 5'd6, "fast");
    lat = 3; stall_mod = 3;
    t_copy(4, 64'h100, 64'h200, 5'd7, "stalled");
    t_zero();
    t_hold();
    t_bad_funct();
    t_bad_opc();
    // R9 and R11: bases still 0x100/0x200 after the unknown and foreign commands
    for (int k = 0; k < 8; k++) mem[32 + k] = 64'h5A5A_0000_0000_0000 | 64'(k);
    lat = 2; stall_mod = 2;
    t_copy(8, 64'h100, 64'h200, 5'd8, "R11 reuse bases");
    t_setup(64'h000, 64'h180, 5'd1);
    lat = 1; stall_mod = 0;
    t_copy(1, 64'h000, 64'h180, 5'd2, "single");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule